// File: doc/BRIEF.md
# Shared Interrupt Line State Register File

This block keeps the per-line state of a configurable set of shared interrupt lines, numbered from 32 up to the implemented line count. For each line it stores a group bit, a group-modifier bit, enable, pending, active, an 8-bit priority, a trigger mode, and a 2-bit field that grants non-secure software limited rights over a secure line. A control word holds three group enables and a security-disable switch. The block publishes all of this as flat vectors for a downstream priority selector.

Software reaches the state over a 32-bit word bus with a 12-bit byte address. Every access carries a secure flag, and each access is answered one cycle later. One-bit-per-line state uses separate set and clear windows. Every line bit is filtered by the access's security attribute and by the line's access field, and each operation has its own threshold. Hardware inputs, one per line, raise pending. The raise is edge-based or level-based, following the line's trigger mode.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset every line field, the control word and `bus_ack` are zero.
- R2: Enable state for line id n sits at bit n%32 of the word at 0x100+4*(n/32) (set window) and 0x180+4*(n/32) (clear window). Writing 1 in the set window sets the bit, writing 1 in the clear window clears it, and writing 0 changes nothing. A read of either window returns the current state.
- R3: Pending uses the same layout at 0x200 (set) and 0x280 (clear), and active uses it at 0x300 (set) and 0x380 (clear). Group bits live at 0x080 and group-modifier bits at 0xD00, both written directly.
- R4: Ids below 32, and ids at or above NUM_LINES, read as zero in every window and ignore writes.
- R5: The priority of line n is byte n%4 (bits 8*(n%4)+7 down to 8*(n%4)) of the word at 0x400+4*(n/4).
- R6: The trigger mode of line n sits at bit 2*(n%16)+1 of the word at 0xC00+4*(n/16): 1 means edge, 0 means level. The even bit of each pair reads as zero.
- R7: The control word at 0x000 has bit 0 = group 0 enable, bit 1 = non-secure group 1 enable, bit 2 = secure group 1 enable and bit 6 = security disable. All other bits read zero. When security disable is 0, a non-secure access sees and changes only bit 1.
- R8: When security disable is 0, a non-secure access treats every line whose group bit is 0 as read-zero and write-ignored. This applies to the group, group-modifier, enable, set-active, priority and trigger windows.
- R9: Under the same condition, two exceptions hold for a line whose group bit is 0. A non-secure set-pending access reaches it when its access field is nonzero. A non-secure clear-pending or clear-active access reaches it when its access field is 2 or 3.
- R10: The access field of line n is bits 2*(n%16)+1 down to 2*(n%16) of the word at 0xE00+4*(n/16). When security disable is 0, a non-secure access reads this window as zero and cannot write it.
- R11: When security disable is 0, a non-secure read of a permitted priority byte returns the stored value shifted left by one with bit 0 cleared. A non-secure write stores {1, data[7:1]}.
- R12: On an edge line, a rising hardware input sets pending. On a level line, a high input sets pending, and a falling input clears pending unless the line is active. When a set and a clear meet in the same cycle, the set wins.
- R13: `bus_ack` is high exactly in the cycle after each `bus_valid`. `bus_rdata` then holds the read value, and holds zero for writes. Unaligned or unmapped addresses read zero and ignore writes.
- R14: With security disable at 1, non-secure accesses behave as secure ones in every window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Secure attribute of the access |
| hw_spi | input | NUM_LINES-32 | Hardware request per line, bit k = id 32+k |
| bus_ack | output | 1 | Response strobe, one cycle after the request |
| bus_rdata | output | 32 | Read data returned with the response |
| spi_group | output | NUM_LINES-32 | Group bit per line |
| spi_grpmod | output | NUM_LINES-32 | Group-modifier bit per line |
| spi_enable | output | NUM_LINES-32 | Enable per line |
| spi_pending | output | NUM_LINES-32 | Pending per line |
| spi_active | output | NUM_LINES-32 | Active per line |
| spi_edge | output | NUM_LINES-32 | Trigger mode per line, 1 = edge |
| spi_prio | output | 8*(NUM_LINES-32) | Priority bytes, byte k = id 32+k |
| spi_nsacc | output | 2*(NUM_LINES-32) | Non-secure access field per line |
| ctl_en_g0 | output | 1 | Group 0 enable |
| ctl_en_g1ns | output | 1 | Non-secure group 1 enable |
| ctl_en_g1s | output | 1 | Secure group 1 enable |
| ctl_ds | output | 1 | Security disable |

## Verification
The hardest case to reach is a non-secure pending or active access to a secure line. It needs that line's access field set to the right level first, and the outcome differs by operation: set-pending passes at field value 1, while clear-pending and clear-active need value 2. The stimulus builds this up in order. Secure writes first mark some lines as non-secure, then give neighbouring secure lines access fields of 0, 1 and 2. Non-secure set and clear bursts then hit all of them in one word, and secure reads show exactly which bits moved. Random secure set and clear traffic on the enable, pending and active windows is checked against a bench model before the directed cases run.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

   localparam int BUS_AW    = 12;
   localparam int BUS_DW    = 32;
   localparam int PRIO_W    = 8;
   localparam int FIRST_SPI = 32;

   typedef enum logic [3:0] {
      W_NONE,
      W_CTRL,
      W_GROUP,
      W_SETEN,
      W_CLREN,
      W_SETPEND,
      W_CLRPEND,
      W_SETACT,
      W_CLRACT,
      W_PRIO,
      W_CFG,
      W_GRPMOD,
      W_NSACC
   } win_e;

   typedef struct packed {
      logic              group;
      logic              grpmod;
      logic              enable;
      logic              pending;
      logic              active;
      logic              edge_mode;
      logic [PRIO_W-1:0] prio;
      logic [1:0]        nsacc;
   } line_state_t;

endpackage

// File: rtl/irq_dist_decode.sv
module irq_dist_decode
   import irq_dist_pkg::*;
(
   input  logic [BUS_AW-1:0] addr,
   output win_e              win,
   output logic [7:0]        off
);

   always_comb begin
      win = W_NONE;
      off = '0;
      if (addr[1:0] == 2'b00) begin
         case (addr[11:7])
            5'd0:  if (addr[6:2] == 5'd0) win = W_CTRL;
            5'd1:  begin win = W_GROUP;   off = {3'b0, addr[6:2]}; end
            5'd2:  begin win = W_SETEN;   off = {3'b0, addr[6:2]}; end
            5'd3:  begin win = W_CLREN;   off = {3'b0, addr[6:2]}; end
            5'd4:  begin win = W_SETPEND; off = {3'b0, addr[6:2]}; end
            5'd5:  begin win = W_CLRPEND; off = {3'b0, addr[6:2]}; end
            5'd6:  begin win = W_SETACT;  off = {3'b0, addr[6:2]}; end
            5'd7:  begin win = W_CLRACT;  off = {3'b0, addr[6:2]}; end
            5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd14, 5'd15:
                   begin win = W_PRIO;    off = addr[9:2]; end
            5'd24, 5'd25:
                   begin win = W_CFG;     off = {2'b0, addr[7:2]}; end
            5'd26: begin win = W_GRPMOD;  off = {3'b0, addr[6:2]}; end
            5'd28, 5'd29:
                   begin win = W_NSACC;   off = {2'b0, addr[7:2]}; end
            default: win = W_NONE;
         endcase
      end
   end

endmodule

// File: rtl/irq_dist_line.sv
module irq_dist_line
   import irq_dist_pkg::*;
#(
   parameter int LANE_BIT  = 0,
   parameter int LANE_BYTE = 0,
   parameter int LANE_PAIR = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_wr,
   input  win_e              win,
   input  logic              sel_bit,
   input  logic              sel_byte,
   input  logic              sel_pair,
   input  logic              ns_restrict,
   input  logic              w_bit,
   input  logic [PRIO_W-1:0] w_byte,
   input  logic [1:0]        w_pair,
   input  logic              hw_in,
   output line_state_t       st,
   output logic [BUS_DW-1:0] rd_part
);

   initial begin
      if (LANE_BIT < 0 || LANE_BIT >= BUS_DW)
         $error("irq_dist_line: LANE_BIT out of range");
      if (LANE_BYTE + PRIO_W > BUS_DW || LANE_PAIR + 2 > BUS_DW)
         $error("irq_dist_line: lane out of range");
   end

   line_state_t st_q;
   logic        hw_prev;
   logic        allow_base, allow_sp, allow_cl, allow_sec;
   logic        bus_set_p, bus_clr_p, hw_set, hw_clr, pend_n;

   assign allow_base = !ns_restrict || st_q.group;
   assign allow_sp   = allow_base || (st_q.nsacc != 2'b00);
   assign allow_cl   = allow_base || st_q.nsacc[1];
   assign allow_sec  = !ns_restrict;

   assign bus_set_p = acc_wr && sel_bit && w_bit && (win == W_SETPEND) && allow_sp;
   assign bus_clr_p = acc_wr && sel_bit && w_bit && (win == W_CLRPEND) && allow_cl;

   // trigger-mode variant of the hardware request path
   always_comb begin
      if (st_q.edge_mode) begin
         hw_set = hw_in && !hw_prev;
         hw_clr = 1'b0;
      end else begin
         hw_set = hw_in;
         hw_clr = hw_prev && !hw_in && !st_q.active;
      end
      pend_n = (st_q.pending && !bus_clr_p && !hw_clr) || bus_set_p || hw_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= '0;
         hw_prev <= 1'b0;
      end else begin
         hw_prev      <= hw_in;
         st_q.pending <= pend_n;
         if (acc_wr && sel_bit && allow_base) begin
            case (win)
               W_GROUP:  st_q.group  <= w_bit;
               W_GRPMOD: st_q.grpmod <= w_bit;
               W_SETEN:  if (w_bit) st_q.enable <= 1'b1;
               W_CLREN:  if (w_bit) st_q.enable <= 1'b0;
               W_SETACT: if (w_bit) st_q.active <= 1'b1;
               default:  ;
            endcase
         end
         if (acc_wr && sel_bit && allow_cl && (win == W_CLRACT) && w_bit)
            st_q.active <= 1'b0;
         if (acc_wr && sel_byte && allow_base && (win == W_PRIO))
            st_q.prio <= ns_restrict ? {1'b1, w_byte[PRIO_W-1:1]} : w_byte;
         if (acc_wr && sel_pair && allow_base && (win == W_CFG))
            st_q.edge_mode <= w_pair[1];
         if (acc_wr && sel_pair && allow_sec && (win == W_NSACC))
            st_q.nsacc <= w_pair;
      end
   end

   always_comb begin
      rd_part = '0;
      case (win)
         W_GROUP:   rd_part[LANE_BIT] = sel_bit && allow_base && st_q.group;
         W_GRPMOD:  rd_part[LANE_BIT] = sel_bit && allow_base && st_q.grpmod;
         W_SETEN,
         W_CLREN:   rd_part[LANE_BIT] = sel_bit && allow_base && st_q.enable;
         W_SETPEND: rd_part[LANE_BIT] = sel_bit && allow_sp && st_q.pending;
         W_CLRPEND: rd_part[LANE_BIT] = sel_bit && allow_cl && st_q.pending;
         W_SETACT:  rd_part[LANE_BIT] = sel_bit && allow_base && st_q.active;
         W_CLRACT:  rd_part[LANE_BIT] = sel_bit && allow_cl && st_q.active;
         W_PRIO:
            if (sel_byte && allow_base)
               rd_part[LANE_BYTE +: PRIO_W] = ns_restrict ?
                  {st_q.prio[PRIO_W-2:0], 1'b0} : st_q.prio;
         W_CFG:     rd_part[LANE_PAIR+1] = sel_pair && allow_base && st_q.edge_mode;
         W_NSACC:
            if (sel_pair && allow_sec) rd_part[LANE_PAIR +: 2] = st_q.nsacc;
         default:   rd_part = '0;
      endcase
   end

   assign st = st_q;

   // R12: a rising input on an edge line leaves the line pending
   a_r12_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q.edge_mode && hw_in && !hw_prev) |=> st_q.pending);

   // R12: a level line whose input dropped and is not active loses pending
   a_r12_level_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_q.edge_mode && hw_prev && !hw_in && !st_q.active && !bus_set_p)
      |=> !st_q.pending);

   // R8: restricted enable writes never touch a secure line
   a_r8_ns_enable_wi: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && ns_restrict && !st_q.group && (win == W_SETEN || win == W_CLREN))
      |=> $stable(st_q.enable));

   // R10: restricted writes never reach the access field
   a_r10_nsacc_secure: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && ns_restrict && (win == W_NSACC)) |=> $stable(st_q.nsacc));

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
   import irq_dist_pkg::*;
#(
   parameter int NUM_LINES = 64,
   localparam int NUM_SPI  = NUM_LINES - FIRST_SPI
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_valid,
   input  logic                     bus_write,
   input  logic [BUS_AW-1:0]        bus_addr,
   input  logic [BUS_DW-1:0]        bus_wdata,
   input  logic                     bus_secure,
   input  logic [NUM_SPI-1:0]       hw_spi,
   output logic                     bus_ack,
   output logic [BUS_DW-1:0]        bus_rdata,
   output logic [NUM_SPI-1:0]       spi_group,
   output logic [NUM_SPI-1:0]       spi_grpmod,
   output logic [NUM_SPI-1:0]       spi_enable,
   output logic [NUM_SPI-1:0]       spi_pending,
   output logic [NUM_SPI-1:0]       spi_active,
   output logic [NUM_SPI-1:0]       spi_edge,
   output logic [NUM_SPI*PRIO_W-1:0] spi_prio,
   output logic [NUM_SPI*2-1:0]     spi_nsacc,
   output logic                     ctl_en_g0,
   output logic                     ctl_en_g1ns,
   output logic                     ctl_en_g1s,
   output logic                     ctl_ds
);

   if (NUM_LINES % BUS_DW != 0 || NUM_LINES < 2 * BUS_DW || NUM_LINES > 992) begin : g_bad_lines
      $error("irq_dist_regs: NUM_LINES must be a multiple of 32 in 64..992");
   end

   win_e              dec_win;
   logic [7:0]        dec_off;
   logic              acc_wr, ns_restrict;
   logic [BUS_DW-1:0] ctrl_view, rd_lines, rd_next;
   logic [BUS_DW-1:0] rd_part [NUM_SPI];
   line_state_t       line_st [NUM_SPI];

   irq_dist_decode u_decode (
      .addr (bus_addr),
      .win  (dec_win),
      .off  (dec_off)
   );

   assign acc_wr      = bus_valid && bus_write;
   assign ns_restrict = !ctl_ds && !bus_secure;

   for (genvar k = 0; k < NUM_SPI; k++) begin : g_line
      localparam int ID = FIRST_SPI + k;
      localparam int LB = ID % BUS_DW;
      localparam int LY = (ID % (BUS_DW / PRIO_W)) * PRIO_W;
      localparam int LP = (ID % (BUS_DW / 2)) * 2;
      logic sel_b, sel_y, sel_p;

      assign sel_b = (dec_off == 8'(ID / BUS_DW));
      assign sel_y = (dec_off == 8'(ID / (BUS_DW / PRIO_W)));
      assign sel_p = (dec_off == 8'(ID / (BUS_DW / 2)));

      irq_dist_line #(
         .LANE_BIT  (LB),
         .LANE_BYTE (LY),
         .LANE_PAIR (LP)
      ) u_line (
         .clk         (clk),
         .rst_n       (rst_n),
         .acc_wr      (acc_wr),
         .win         (dec_win),
         .sel_bit     (sel_b),
         .sel_byte    (sel_y),
         .sel_pair    (sel_p),
         .ns_restrict (ns_restrict),
         .w_bit       (bus_wdata[LB]),
         .w_byte      (bus_wdata[LY +: PRIO_W]),
         .w_pair      (bus_wdata[LP +: 2]),
         .hw_in       (hw_spi[k]),
         .st          (line_st[k]),
         .rd_part     (rd_part[k])
      );

      assign spi_group[k]             = line_st[k].group;
      assign spi_grpmod[k]            = line_st[k].grpmod;
      assign spi_enable[k]            = line_st[k].enable;
      assign spi_pending[k]           = line_st[k].pending;
      assign spi_active[k]            = line_st[k].active;
      assign spi_edge[k]              = line_st[k].edge_mode;
      assign spi_prio[k*PRIO_W +: PRIO_W] = line_st[k].prio;
      assign spi_nsacc[k*2 +: 2]      = line_st[k].nsacc;
   end

   always_comb begin
      rd_lines = '0;
      for (int k = 0; k < NUM_SPI; k++) rd_lines = rd_lines | rd_part[k];
   end

   always_comb begin
      ctrl_view = '0;
      ctrl_view[1] = ctl_en_g1ns;
      if (!ns_restrict) begin
         ctrl_view[0] = ctl_en_g0;
         ctrl_view[2] = ctl_en_g1s;
         ctrl_view[6] = ctl_ds;
      end
      rd_next = (dec_win == W_CTRL) ? ctrl_view : rd_lines;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en_g0   <= 1'b0;
         ctl_en_g1ns <= 1'b0;
         ctl_en_g1s  <= 1'b0;
         ctl_ds      <= 1'b0;
      end else if (acc_wr && dec_win == W_CTRL) begin
         ctl_en_g1ns <= bus_wdata[1];
         if (!ns_restrict) begin
            ctl_en_g0  <= bus_wdata[0];
            ctl_en_g1s <= bus_wdata[2];
            ctl_ds     <= bus_wdata[6];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_ack   <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ack   <= bus_valid;
         bus_rdata <= (bus_valid && !bus_write) ? rd_next : '0;
      end
   end

   // R13: each request is answered in the next cycle, and only then
   a_r13_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |=> bus_ack);
   a_r13_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> !bus_ack);
   a_r13_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write) |=> (bus_rdata == '0));

   // R7: reserved control bits never appear on a control read
   a_r7_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && dec_win == W_CTRL)
      |=> (bus_rdata[31:7] == '0 && bus_rdata[5:3] == '0));

endmodule

// File: tb/irq_dist_regs_bench.sv
`timescale 1ns/1ps
module irq_dist_regs_bench;
   localparam int NL = 64;
   localparam int NS = NL - 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0, bus_write = 1'b0, bus_secure = 1'b1;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [NS-1:0] hw_spi = '0;
   logic          bus_ack;
   logic [31:0]   bus_rdata;
   logic [NS-1:0] spi_group, spi_grpmod, spi_enable, spi_pending, spi_active, spi_edge;
   logic [NS*8-1:0] spi_prio;
   logic [NS*2-1:0] spi_nsacc;
   logic          ctl_en_g0, ctl_en_g1ns, ctl_en_g1s, ctl_ds;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_dist_regs #(.NUM_LINES(NL)) u_irq_dist_regs (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
      .hw_spi(hw_spi), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .spi_group(spi_group), .spi_grpmod(spi_grpmod), .spi_enable(spi_enable),
      .spi_pending(spi_pending), .spi_active(spi_active), .spi_edge(spi_edge),
      .spi_prio(spi_prio), .spi_nsacc(spi_nsacc), .ctl_en_g0(ctl_en_g0),
      .ctl_en_g1ns(ctl_en_g1ns), .ctl_en_g1s(ctl_en_g1s), .ctl_ds(ctl_ds)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // one access: drive at a falling edge, sample the response at the next one
   task automatic acc(input bit wr, input logic [11:0] a, input logic [31:0] d,
                      input bit sec, output logic [31:0] rd);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d; bus_secure = sec;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      rd = bus_rdata;
      if (!bus_ack) begin
         n_chk++; n_fail++;
         $display("FAIL R13 actual ack=0 expected ack=1");
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit sec);
      logic [31:0] dummy;
      acc(1'b1, a, d, sec, dummy);
   endtask

   task automatic rdchk(input string req, input logic [11:0] a, input bit sec,
                        input logic [31:0] exp);
      logic [31:0] v;
      acc(1'b0, a, 32'h0, sec, v);
      chk(req, v, exp);
   endtask

   function automatic logic [31:0] apply_op(input logic [31:0] old, input bit set,
                                            input logic [31:0] d);
      return set ? (old | d) : (old & ~d);
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] m_en, m_pd, m_ac, d, v;
      int seed;
      seed = 32'h1d57;
      void'($urandom(seed));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 ack", {31'b0, bus_ack}, 32'h0);
      chk("R1 enable", spi_enable, 32'h0);
      chk("R1 pending", spi_pending | spi_active | spi_group | spi_edge, 32'h0);
      chk("R1 prio", spi_prio[31:0] | spi_prio[255:224], 32'h0);
      chk("R1 ctrl", {28'b0, ctl_ds, ctl_en_g1s, ctl_en_g1ns, ctl_en_g0}, 32'h0);
      rdchk("R1 ctrl read", 12'h000, 1'b1, 32'h0);

      // R2/R3 constrained random set/clear traffic, secure
      m_en = '0; m_pd = '0; m_ac = '0;
      for (int it = 0; it < 150; it++) begin
         int op;
         bit set;
         logic [11:0] base;
         op   = $urandom_range(0, 5);
         set  = (op % 2) == 0;
         d    = $urandom;
         base = 12'h104 + 12'(12'h100 * (op / 2)) + (set ? 12'h0 : 12'h080);
         wr(base, d, 1'b1);
         case (op / 2)
            0: m_en = apply_op(m_en, set, d);
            1: m_pd = apply_op(m_pd, set, d);
            default: m_ac = apply_op(m_ac, set, d);
         endcase
         if (it % 25 == 0) begin
            rdchk("R2 enable set-window read", 12'h104, 1'b1, m_en);
            rdchk("R2 enable clear-window read", 12'h184, 1'b1, m_en);
            rdchk("R3 pending read", 12'h284, 1'b1, m_pd);
            rdchk("R3 active read", 12'h304, 1'b1, m_ac);
         end
      end
      chk("R2 enable vector", spi_enable, m_en);
      chk("R3 pending vector", spi_pending, m_pd);
      chk("R3 active vector", spi_active, m_ac);
      wr(12'h184, 32'hFFFF_FFFF, 1'b1);
      wr(12'h284, 32'hFFFF_FFFF, 1'b1);
      wr(12'h384, 32'hFFFF_FFFF, 1'b1);
      wr(12'h084, 32'h0000_00F0, 1'b1);
      wr(12'hD04, 32'h0000_0F00, 1'b1);
      rdchk("R3 group read", 12'h084, 1'b1, 32'h0000_00F0);
      rdchk("R3 group-modifier read", 12'hD04, 1'b1, 32'h0000_0F00);
      wr(12'h084, 32'h0, 1'b1);

      // R4 out-of-range ids
      wr(12'h100, 32'hFFFF_FFFF, 1'b1);
      rdchk("R4 ids 0-31 enable", 12'h100, 1'b1, 32'h0);
      wr(12'h108, 32'hFFFF_FFFF, 1'b1);
      rdchk("R4 ids 64-95 enable", 12'h108, 1'b1, 32'h0);
      wr(12'h400, 32'hFFFF_FFFF, 1'b1);
      rdchk("R4 ids 0-3 priority", 12'h400, 1'b1, 32'h0);
      chk("R4 no line enabled", spi_enable, 32'h0);

      // R5 priority bytes
      wr(12'h420, 32'h4433_2211, 1'b1);
      chk("R5 id33 priority", {24'b0, spi_prio[15:8]}, 32'h22);
      rdchk("R5 priority readback", 12'h420, 1'b1, 32'h4433_2211);

      // R6 trigger mode
      wr(12'hC08, 32'hFFFF_FFFF, 1'b1);
      rdchk("R6 odd bits only", 12'hC08, 1'b1, 32'hAAAA_AAAA);
      chk("R6 edge vector", {16'b0, spi_edge[15:0]}, 32'h0000_FFFF);
      wr(12'hC08, 32'h0, 1'b1);

      // R7 control word
      wr(12'h000, 32'hFFFF_FFBF, 1'b1);
      rdchk("R7 secure ctrl", 12'h000, 1'b1, 32'h07);
      wr(12'h000, 32'h0, 1'b0);
      rdchk("R7 ns write touches bit1 only", 12'h000, 1'b1, 32'h05);
      rdchk("R7 ns view", 12'h000, 1'b0, 32'h0);
      wr(12'h000, 32'h2, 1'b0);
      rdchk("R7 ns view bit1", 12'h000, 1'b0, 32'h2);
      chk("R7 group1s output", {31'b0, ctl_en_g1s}, 32'h1);

      // R8 secure lines hidden from non-secure software
      wr(12'h084, 32'h0000_FFFF, 1'b1);
      wr(12'h104, 32'h1000_0000, 1'b1);
      wr(12'h104, 32'hFFFF_FFFF, 1'b0);
      rdchk("R8 secure view of enable", 12'h104, 1'b1, 32'h1000_FFFF);
      rdchk("R8 ns view of enable", 12'h104, 1'b0, 32'h0000_FFFF);
      wr(12'h430, 32'hFFFF_FFFF, 1'b0);
      rdchk("R8 ns priority write to secure line", 12'h430, 1'b1, 32'h0);
      wr(12'h304, 32'h0004_0000, 1'b0);
      rdchk("R8 ns set-active on secure line", 12'h304, 1'b1, 32'h0);

      // R11 non-secure priority view
      wr(12'h420, 32'h0000_00A4, 1'b0);
      rdchk("R11 stored value", 12'h420, 1'b1, 32'h8080_80D2);
      rdchk("R11 ns view", 12'h420, 1'b0, 32'h0000_00A4);

      // R9/R10 access field thresholds: id48=1, id49=2, id50=0
      wr(12'hE0C, 32'h0000_0009, 1'b1);
      wr(12'hE0C, 32'hFFFF_FFFF, 1'b0);
      rdchk("R10 ns write ignored", 12'hE0C, 1'b1, 32'h0000_0009);
      rdchk("R10 ns read zero", 12'hE0C, 1'b0, 32'h0);
      wr(12'h204, 32'hFFFF_0000, 1'b0);
      rdchk("R9 ns set-pending threshold", 12'h204, 1'b1, 32'h0003_0000);
      wr(12'h284, 32'hFFFF_0000, 1'b0);
      rdchk("R9 ns clear-pending threshold", 12'h204, 1'b1, 32'h0001_0000);
      rdchk("R9 ns clear-pending view", 12'h284, 1'b0, 32'h0);
      wr(12'h304, 32'h0003_0000, 1'b1);
      wr(12'h384, 32'hFFFF_0000, 1'b0);
      rdchk("R9 ns clear-active threshold", 12'h304, 1'b1, 32'h0001_0000);

      // R14 security disabled
      wr(12'h000, 32'h0000_0047, 1'b1);
      wr(12'h104, 32'hFFFF_0000, 1'b0);
      rdchk("R14 ns enable reaches all", 12'h104, 1'b1, 32'hFFFF_FFFF);
      rdchk("R14 ns access field visible", 12'hE0C, 1'b0, 32'h0000_0009);
      rdchk("R14 ns priority raw", 12'h420, 1'b0, 32'h8080_80D2);
      rdchk("R14 ns ctrl full", 12'h000, 1'b0, 32'h0000_0047);
      wr(12'h000, 32'h0000_0007, 1'b1);

      // R12 hardware requests: id40 level (k=8), id41 edge (k=9)
      wr(12'hC08, 32'h0008_0000, 1'b1);
      @(negedge clk); hw_spi[8] = 1'b1;
      @(negedge clk); chk("R12 level high sets", {31'b0, spi_pending[8]}, 32'h1);
      hw_spi[8] = 1'b0;
      @(negedge clk); chk("R12 level drop clears", {31'b0, spi_pending[8]}, 32'h0);
      hw_spi[9] = 1'b1;
      @(negedge clk); chk("R12 edge rise sets", {31'b0, spi_pending[9]}, 32'h1);
      wr(12'h284, 32'h0000_0200, 1'b1);
      chk("R12 edge held high no re-set", {31'b0, spi_pending[9]}, 32'h0);
      hw_spi[9] = 1'b0;
      wr(12'h304, 32'h0000_0100, 1'b1);
      @(negedge clk); hw_spi[8] = 1'b1;
      @(negedge clk); hw_spi[8] = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R12 active level line keeps pending", {31'b0, spi_pending[8]}, 32'h1);

      // R13 response rules
      acc(1'b1, 12'h104, 32'h1, 1'b1, v);
      chk("R13 write returns zero", v, 32'h0);
      wr(12'h185, 32'hFFFF_FFFF, 1'b1);
      rdchk("R13 unaligned write ignored", 12'h104, 1'b1, 32'hFFFF_FFFF);
      rdchk("R13 unaligned read zero", 12'h105, 1'b1, 32'h0);
      rdchk("R13 unmapped read zero", 12'h004, 1'b1, 32'h0);
      @(negedge clk);
      chk("R13 ack drops when idle", {31'b0, bus_ack}, 32'h0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule